// File: doc/BRIEF.md
# Debug Clock Synchronizer with Returned Clock

This block brings the slow, asynchronous debug clock from an external probe, together with its mode-select and data-in lines, into the core clock domain. The debug clock and both data lines are resynchronized by a flip-flop chain. A rising edge of the resynchronized debug clock is turned into a clock-enable pulse one core cycle long. Debug logic uses this pulse in place of a separate debug clock domain. The mode-select and data-in values captured with that edge are presented on the synchronized outputs. They are then held until the next rising edge.

The last resynchronized copy of the debug clock is sent back to the probe as a returned clock. A probe that waits for each returned-clock transition before it moves its debug clock never outruns the synchronizer. A bypass input switches the enable and the two data outputs to the raw pins. Every flip-flop is cleared by the asynchronous active-low test reset.

Top module: `dbg_clk_sync`

## Requirements
- R1: While `trst_n_i` is low, `rtck_o`, `tck_en_o`, `tms_o` and `tdi_o` are 0 with `bypass_i` low.
- R2: With `bypass_i` low, each rising edge of `tck_i` produces exactly one `tck_en_o` pulse, one core cycle wide, visible in the cycle after the second rising core clock edge following the change.
- R3: `rtck_o` follows `tck_i` for both edges after exactly SYNC_STAGES rising core clock edges (3 by default), one cycle after the enable pulse for a rising edge.
- R4: During the `tck_en_o` cycle, `tms_o` and `tdi_o` show the values `tms_i` and `tdi_i` had when `tck_i` rose, because they are resynchronized through the same number of stages.
- R5: A falling edge of `tck_i` produces no `tck_en_o` pulse.
- R6: With `bypass_i` high, `tck_en_o` equals the raw `tck_i` level and `tms_o`, `tdi_o` equal `tms_i`, `tdi_i` with no delay.
- R7: With `bypass_i` low, changes on `tms_i` or `tdi_i` between rising edges of `tck_i` leave `tms_o` and `tdi_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| trst_n_i | input | 1 | Asynchronous active-low test reset for all flip-flops |
| tck_i | input | 1 | Debug clock from the probe |
| tms_i | input | 1 | Mode-select line from the probe |
| tdi_i | input | 1 | Data-in line from the probe |
| bypass_i | input | 1 | 1 routes the raw pins to the enable and data outputs |
| rtck_o | output | 1 | Returned debug clock to the probe |
| tck_en_o | output | 1 | Core-domain debug clock enable |
| tms_o | output | 1 | Synchronized, held mode-select |
| tdi_o | output | 1 | Synchronized, held data-in |

## Verification
The assertions assume the probe keeps each `tck_i` level until the matching `rtck_o` transition has appeared. They also assume `tms_i` and `tdi_i` are stable when `tck_i` rises. Under these conditions, enable pulses can never occur on consecutive cycles, and the returned clock only rises directly after an enable. The bench acts as such a probe. It changes `tck_i` only after it has seen `rtck_o` follow, and it sets the data lines in the same cycle as the clock edge. It changes the data lines only after the enable pulse. All stimulus is driven on the falling core clock edge, so none of it lands on a sampling edge.

// File: rtl/dbg_sync_pkg.sv
package dbg_sync_pkg;

    typedef struct packed {
        logic tms;
        logic tdi;
    } pin_pair_t;

    typedef struct packed {
        logic      tck_dly;
        pin_pair_t hold;
    } hold_state_t;

endpackage

// File: rtl/dbg_sync_chain.sv
module dbg_sync_chain #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_comb begin
        stage_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dbg_edge_hold.sv
module dbg_edge_hold
    import dbg_sync_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_n_i,
    input  logic      tck_s_i,
    input  pin_pair_t pins_s_i,
    output logic      en_o,
    output logic      rtck_o,
    output pin_pair_t pins_o
);

    hold_state_t st_d;
    hold_state_t st_q;
    logic        en_d;

    always_comb begin
        st_d         = st_q;
        en_d         = tck_s_i & ~st_q.tck_dly;
        st_d.tck_dly = tck_s_i;
        if (en_d) begin
            st_d.hold = pins_s_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = en_d;
    assign rtck_o = st_q.tck_dly;
    assign pins_o = en_d ? pins_s_i : st_q.hold;

    // R2: an enable never lasts two cycles
    a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        en_o |=> !en_o);

    // R4: the captured pair is still presented once the pulse ends
    a_r4_capture_kept: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        en_o |=> pins_o == $past(pins_s_i));

endmodule

// File: rtl/dbg_clk_sync.sv
module dbg_clk_sync
    import dbg_sync_pkg::*;
#(
    parameter int SYNC_STAGES = 3
) (
    input  logic clk_i,
    input  logic trst_n_i,
    input  logic tck_i,
    input  logic tms_i,
    input  logic tdi_i,
    input  logic bypass_i,
    output logic rtck_o,
    output logic tck_en_o,
    output logic tms_o,
    output logic tdi_o
);

    localparam int CHAIN_STAGES = SYNC_STAGES - 1;
    localparam int CHAIN_WIDTH  = 1 + $bits(pin_pair_t);

    logic [CHAIN_WIDTH-1:0] chain_in;
    logic [CHAIN_WIDTH-1:0] chain_out;
    pin_pair_t              pins_s;
    pin_pair_t              pins_held;
    logic                   en_sync;

    assign chain_in = {tck_i, tms_i, tdi_i};
    assign pins_s   = pin_pair_t'(chain_out[CHAIN_WIDTH-2:0]);

    dbg_sync_chain #(
        .WIDTH  (CHAIN_WIDTH),
        .STAGES (CHAIN_STAGES)
    ) u_chain (
        .clk_i   (clk_i),
        .rst_n_i (trst_n_i),
        .d_i     (chain_in),
        .q_o     (chain_out)
    );

    dbg_edge_hold u_hold (
        .clk_i    (clk_i),
        .rst_n_i  (trst_n_i),
        .tck_s_i  (chain_out[CHAIN_WIDTH-1]),
        .pins_s_i (pins_s),
        .en_o     (en_sync),
        .rtck_o   (rtck_o),
        .pins_o   (pins_held)
    );

    always_comb begin
        if (bypass_i) begin
            tck_en_o = tck_i;
            tms_o    = tms_i;
            tdi_o    = tdi_i;
        end else begin
            tck_en_o = en_sync;
            tms_o    = pins_held.tms;
            tdi_o    = pins_held.tdi;
        end
    end

    // R3: the returned clock rises only right after an enable pulse
    a_r3_rtck_after_en: assert property (@(posedge clk_i) disable iff (!trst_n_i)
        $rose(rtck_o) |-> $past(en_sync));

    // R5: a falling returned clock is never preceded by an enable
    a_r5_no_en_on_fall: assert property (@(posedge clk_i) disable iff (!trst_n_i)
        $fell(rtck_o) |-> !$past(en_sync));

    // R7: without an enable the synchronized outputs stay put
    a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!trst_n_i)
        (!bypass_i && !$past(bypass_i) && !tck_en_o && !$past(en_sync))
            |-> ($stable(tms_o) && $stable(tdi_o)));

endmodule

// File: tb/dbg_clk_sync_bench.sv
module dbg_clk_sync_bench;

    logic clk = 1'b0;
    logic trst_n;
    logic tck, tms, tdi, bypass;
    logic rtck, tck_en, tms_o, tdi_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    dbg_clk_sync u_dbg_clk_sync (
        .clk_i    (clk),
        .trst_n_i (trst_n),
        .tck_i    (tck),
        .tms_i    (tms),
        .tdi_i    (tdi),
        .bypass_i (bypass),
        .rtck_o   (rtck),
        .tck_en_o (tck_en),
        .tms_o    (tms_o),
        .tdi_o    (tdi_o)
    );

    // {tms, tdi, expected tms_o, expected tdi_o}
    localparam logic [3:0] VEC [8] = '{
        4'b1111, 4'b0000, 4'b1010, 4'b0101,
        4'b1111, 4'b1010, 4'b0000, 4'b0101
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic rise_edge(input logic v_tms, input logic v_tdi,
                             input logic e_tms, input logic e_tdi);
        int en_cnt = 0;
        int en_at  = -1;
        int rt_at  = -1;
        logic c_tms = 1'b0;
        logic c_tdi = 1'b0;
        @(negedge clk);
        tck = 1'b1; tms = v_tms; tdi = v_tdi;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (tck_en) begin
                en_cnt++; en_at = k; c_tms = tms_o; c_tdi = tdi_o;
            end
            if (rtck && rt_at < 0) rt_at = k;
            if (k == 3) begin
                tms = ~v_tms; tdi = ~v_tdi;
            end
        end
        check(en_cnt == 1, "R2 pulse count", en_cnt, 1);
        check(en_at == 2, "R2 pulse cycle", en_at, 2);
        check(rt_at == 3, "R3 rtck rise latency", rt_at, 3);
        check(c_tms == e_tms, "R4 tms at enable", c_tms, e_tms);
        check(c_tdi == e_tdi, "R4 tdi at enable", c_tdi, e_tdi);
        check(tms_o == e_tms && tdi_o == e_tdi, "R7 held pair",
              {tms_o, tdi_o}, {e_tms, e_tdi});
    endtask

    task automatic fall_edge();
        int en_cnt = 0;
        int rt_at  = -1;
        @(negedge clk);
        tck = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (tck_en) en_cnt++;
            if (!rtck && rt_at < 0) rt_at = k;
        end
        check(en_cnt == 0, "R5 no pulse on fall", en_cnt, 0);
        check(rt_at == 3, "R3 rtck fall latency", rt_at, 3);
    endtask

    initial begin
        trst_n = 1'b0; tck = 1'b0; tms = 1'b0; tdi = 1'b0; bypass = 1'b0;
        repeat (3) @(negedge clk);
        tck = 1'b1; tms = 1'b1; tdi = 1'b1;
        repeat (4) @(negedge clk);
        check(rtck == 0 && tck_en == 0 && tms_o == 0 && tdi_o == 0, "R1 reset state",
              {rtck, tck_en, tms_o, tdi_o}, 0);
        tck = 1'b0; tms = 1'b0; tdi = 1'b0;
        @(negedge clk);
        trst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            rise_edge(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
            fall_edge();
        end

        // R7: toggle data lines with TCK idle low
        @(negedge clk);
        tms = ~tms; tdi = ~tdi;
        repeat (5) @(negedge clk);
        check(tms_o == VEC[7][1] && tdi_o == VEC[7][0], "R7 idle data change",
              {tms_o, tdi_o}, {VEC[7][1], VEC[7][0]});

        // R6: bypass follows raw pins
        bypass = 1'b1; tck = 1'b1; tms = 1'b1; tdi = 1'b0;
        #1;
        check(tck_en == 1 && tms_o == 1 && tdi_o == 0, "R6 bypass high",
              {tck_en, tms_o, tdi_o}, 3'b110);
        @(negedge clk);
        tck = 1'b0; tms = 1'b0; tdi = 1'b1;
        #1;
        check(tck_en == 0 && tms_o == 0 && tdi_o == 1, "R6 bypass low",
              {tck_en, tms_o, tdi_o}, 3'b001);
        repeat (5) @(negedge clk);
        bypass = 1'b0;
        repeat (2) @(negedge clk);

        // resume normal edges after bypass
        rise_edge(1'b0, 1'b1, 1'b0, 1'b1);
        fall_edge();

        // R1: asynchronous reset mid-run
        @(negedge clk);
        tck = 1'b1; tms = 1'b1; tdi = 1'b1;
        repeat (3) @(negedge clk);
        #2 trst_n = 1'b0;
        #1;
        check(rtck == 0 && tck_en == 0 && tms_o == 0 && tdi_o == 0, "R1 async reset",
              {rtck, tck_en, tms_o, tdi_o}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule